// File: doc/BRIEF.md
# USB Endpoint-Zero Control Register with Write Interlock

This block holds the control and status byte for USB endpoint 0. Two agents write it: a CPU through a plain register port with read and write strobes, and the serial interface engine (SIE) through event strobes and a mode-update port. The byte carries four event flags (setup seen, IN acknowledged by the host, OUT completed, any transaction acknowledged) in its upper half and a mode field in its lower half.

Any SIE update locks the register, and the CPU cannot write it again until it has read it. The CPU therefore cannot overwrite state it has not yet seen. A write that the lock allows always clears all four flags, whatever the data, and loads the mode from the low bits. While a setup packet is being received, the setup flag is forced on. While that flag is set, a gate output refuses CPU writes to the endpoint-0 data buffer, so unread setup bytes cannot be overwritten.

Top module: `ep0_ctrl_lock`

## Requirements
- R1: After reset, the register reads 0x00 and is unlocked, so the first CPU write takes effect.
- R2: Any SIE strobe (setup start, setup ACK start, IN acknowledged, OUT done, transaction acknowledged, mode update, count-register write) locks the register. A CPU write while it is locked, without a read in the same cycle, leaves the register unchanged.
- R3: A CPU read strobe with no SIE strobe in that cycle clears the lock. A write whose cycle also carries the read strobe is accepted.
- R4: An accepted CPU write sets bits 7..4 to zero, whatever the data written, and loads bits 3..0 from the written data.
- R5: Setup start sets bit 7 and starts a forced window that ends on the setup ACK strobe. During the window an accepted CPU write cannot clear bit 7, though it still clears bits 6..4 and loads the mode.
- R6: After the forced window ends, bit 7 stays 1 until an accepted CPU write clears it.
- R7: The data-buffer write enable equals the buffer write request while bit 7 is 0, and is 0 while bit 7 is 1.
- R8: The IN-acknowledged strobe sets bit 6.
- R9: The OUT-done strobe sets bit 5.
- R10: The transaction-acknowledged strobe sets bit 4.
- R11: A mode-update strobe from the SIE loads bits 3..0 from the SIE mode data.
- R12: If an SIE strobe and a CPU write arrive in the same cycle, the SIE update is applied, the CPU write is dropped, no flag set in that cycle is lost, and the register is locked afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuRd | input | 1 | CPU read strobe for the control register |
| cpuWr | input | 1 | CPU write strobe for the control register |
| cpuWrData | input | 8 | CPU write data |
| cpuRdData | output | 8 | Current register value {setup, in, out, ack, mode} |
| cpuBufWrReq | input | 1 | CPU request to write the endpoint-0 data buffer |
| cpuBufWrEn | output | 1 | Gated data-buffer write enable |
| sieSetupStart | input | 1 | SIE: setup data packet begins |
| sieSetupAck | input | 1 | SIE: ACK for setup begins, ends the forced window |
| sieInAcked | input | 1 | SIE: host acknowledged an IN packet |
| sieOutDone | input | 1 | SIE: last OUT packet received and ACKed |
| sieAcked | input | 1 | SIE: a transaction finished with ACK |
| sieModeWr | input | 1 | SIE: load a new mode |
| sieModeData | input | 4 | SIE mode value |
| sieCntWr | input | 1 | SIE wrote the count register (locks only) |

## Verification
On every cycle the assertions check that an SIE strobe leaves the register locked and that a read with no SIE activity unlocks it. They also check that a locked write with no read leaves the value unchanged, that bit 7 holds through the forced window, and that the buffer gate is closed while setup is pending. The directed scenarios are needed for the value a write leaves behind, the combined read-and-write cycle, and the way bit 7 outlives the ACK strobe. They also cover the collision where an SIE event and a CPU write share a cycle and the SIE update must win.

// File: rtl/ep0_lock_pkg.sv
`timescale 1ns/1ps
package ep0_lock_pkg;
  localparam int FLAG_W = 4;

  typedef struct packed {
    logic clrFlags;
    logic ldCpuMode;
    logic ldSieMode;
    logic setSetup;
    logic endForce;
    logic setIn;
    logic setOut;
    logic setAck;
  } ep0Strobes_t;
endpackage

// File: rtl/ep0_lock_ctrl.sv
`timescale 1ns/1ps
module ep0_lock_ctrl
  import ep0_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuRd,
  input  logic        cpuWr,
  input  logic        sieSetupStart,
  input  logic        sieSetupAck,
  input  logic        sieInAcked,
  input  logic        sieOutDone,
  input  logic        sieAcked,
  input  logic        sieModeWr,
  input  logic        sieCntWr,
  output ep0Strobes_t strb,
  output logic        locked
);
  logic sieAny;
  logic cpuWrOk;

  assign sieAny = sieSetupStart | sieSetupAck | sieInAcked | sieOutDone |
                  sieAcked | sieModeWr | sieCntWr;

  // A read in the same cycle unlocks, so a write in that cycle is accepted. SIE wins ties.
  assign cpuWrOk = cpuWr && (!locked || cpuRd) && !sieAny;

  always_comb begin
    strb           = '0;
    strb.clrFlags  = cpuWrOk;
    strb.ldCpuMode = cpuWrOk;
    strb.ldSieMode = sieModeWr;
    strb.setSetup  = sieSetupStart;
    strb.endForce  = sieSetupAck;
    strb.setIn     = sieInAcked;
    strb.setOut    = sieOutDone;
    strb.setAck    = sieAcked;
  end

  always_ff @(posedge clk) begin
    if (!rstN)       locked <= 1'b0;
    else if (sieAny) locked <= 1'b1;
    else if (cpuRd)  locked <= 1'b0;
  end

  AST_LOCK_AFTER_SIE: assert property (@(posedge clk) disable iff (!rstN)
    sieAny |=> locked); // R2
  AST_READ_UNLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && !sieAny) |=> !locked); // R3
endmodule

// File: rtl/ep0_lock_dp.sv
`timescale 1ns/1ps
module ep0_lock_dp
  import ep0_lock_pkg::*;
#(
  parameter int MODE_W = 4,
  localparam int DATA_W = MODE_W + FLAG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ep0Strobes_t       strb,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [MODE_W-1:0] sieModeData,
  input  logic              cpuBufWrReq,
  output logic [DATA_W-1:0] regVal,
  output logic              cpuBufWrEn
);
  logic              setupFlag, inFlag, outFlag, ackFlag, setupForced;
  logic [MODE_W-1:0] modeReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      setupFlag   <= 1'b0;
      inFlag      <= 1'b0;
      outFlag     <= 1'b0;
      ackFlag     <= 1'b0;
      setupForced <= 1'b0;
      modeReg     <= '0;
    end else begin
      if (strb.setSetup)      setupForced <= 1'b1;
      else if (strb.endForce) setupForced <= 1'b0;

      if (strb.setSetup)                      setupFlag <= 1'b1;
      else if (strb.clrFlags && !setupForced) setupFlag <= 1'b0;

      if (strb.setIn)         inFlag <= 1'b1;
      else if (strb.clrFlags) inFlag <= 1'b0;

      if (strb.setOut)        outFlag <= 1'b1;
      else if (strb.clrFlags) outFlag <= 1'b0;

      if (strb.setAck)        ackFlag <= 1'b1;
      else if (strb.clrFlags) ackFlag <= 1'b0;

      if (strb.ldSieMode)      modeReg <= sieModeData;
      else if (strb.ldCpuMode) modeReg <= cpuWrData[MODE_W-1:0];
    end
  end

  assign regVal     = {setupFlag, inFlag, outFlag, ackFlag, modeReg};
  assign cpuBufWrEn = cpuBufWrReq & ~setupFlag;

  AST_SETUP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    setupForced |-> setupFlag); // R5
  AST_IN_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strb.setIn |=> inFlag); // R8
endmodule

// File: rtl/ep0_ctrl_lock.sv
`timescale 1ns/1ps
module ep0_ctrl_lock
  import ep0_lock_pkg::*;
#(
  parameter int MODE_W = 4,
  localparam int DATA_W = MODE_W + FLAG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [DATA_W-1:0] cpuRdData,
  input  logic              cpuBufWrReq,
  output logic              cpuBufWrEn,
  input  logic              sieSetupStart,
  input  logic              sieSetupAck,
  input  logic              sieInAcked,
  input  logic              sieOutDone,
  input  logic              sieAcked,
  input  logic              sieModeWr,
  input  logic [MODE_W-1:0] sieModeData,
  input  logic              sieCntWr
);
  ep0Strobes_t strb;
  logic        locked;

  ep0_lock_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .sieSetupStart(sieSetupStart), .sieSetupAck(sieSetupAck),
    .sieInAcked(sieInAcked), .sieOutDone(sieOutDone), .sieAcked(sieAcked),
    .sieModeWr(sieModeWr), .sieCntWr(sieCntWr),
    .strb(strb), .locked(locked)
  );

  ep0_lock_dp #(.MODE_W(MODE_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .cpuWrData(cpuWrData),
    .sieModeData(sieModeData), .cpuBufWrReq(cpuBufWrReq),
    .regVal(cpuRdData), .cpuBufWrEn(cpuBufWrEn)
  );

  AST_LOCKED_WR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (locked && cpuWr && !cpuRd && !(|strb)) |=> $stable(cpuRdData)); // R2
  AST_BUF_GATE: assert property (@(posedge clk) disable iff (!rstN)
    cpuRdData[DATA_W-1] |-> !cpuBufWrEn); // R7
endmodule

// File: tb/tb_ep0_ctrl_lock.sv
`timescale 1ns/1ps
module tb_ep0_ctrl_lock;
  logic       clk = 1'b0, rstN = 1'b0;
  logic       cpuRd = 0, cpuWr = 0, cpuBufWrReq = 0;
  logic [7:0] cpuWrData = '0;
  logic [7:0] cpuRdData;
  logic       cpuBufWrEn;
  logic       sieSetupStart = 0, sieSetupAck = 0, sieInAcked = 0, sieOutDone = 0;
  logic       sieAcked = 0, sieModeWr = 0, sieCntWr = 0;
  logic [3:0] sieModeData = '0;
  int         nRun = 0, nFail = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  ep0_ctrl_lock dut (
    .clk(clk), .rstN(rstN), .cpuRd(cpuRd), .cpuWr(cpuWr), .cpuWrData(cpuWrData),
    .cpuRdData(cpuRdData), .cpuBufWrReq(cpuBufWrReq), .cpuBufWrEn(cpuBufWrEn),
    .sieSetupStart(sieSetupStart), .sieSetupAck(sieSetupAck), .sieInAcked(sieInAcked),
    .sieOutDone(sieOutDone), .sieAcked(sieAcked), .sieModeWr(sieModeWr),
    .sieModeData(sieModeData), .sieCntWr(sieCntWr)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    cpuRd = 0; cpuWr = 0; sieSetupStart = 0; sieSetupAck = 0; sieInAcked = 0;
    sieOutDone = 0; sieAcked = 0; sieModeWr = 0; sieCntWr = 0;
  endtask

  task automatic cpuWrite(input logic [7:0] d);
    cpuWr = 1; cpuWrData = d; tick();
  endtask
  task automatic cpuRead();
    cpuRd = 1; tick();
  endtask
  task automatic cpuRdWr(input logic [7:0] d);
    cpuRd = 1; cpuWr = 1; cpuWrData = d; tick();
  endtask

  task automatic testReset();
    chk("R1 reset value", cpuRdData, 8'h00);
    cpuWrite(8'h05);
    chk("R1 first write accepted", cpuRdData, 8'h05);
  endtask

  task automatic testLockedWrite();
    sieAcked = 1; tick();
    chk("R10 ack flag", cpuRdData, 8'h15);
    cpuWrite(8'h0A);
    chk("R2 write ignored after event", cpuRdData, 8'h15);
    cpuRead();
    sieCntWr = 1; tick();
    cpuWrite(8'h0A);
    chk("R2 count write locks", cpuRdData, 8'h15);
  endtask

  task automatic testReadUnlock();
    cpuRead();
    cpuWrite(8'hFA);
    chk("R4 upper cleared, mode loaded", cpuRdData, 8'h0A);
    sieInAcked = 1; tick();
    chk("R8 in flag", cpuRdData, 8'h4A);
    cpuRdWr(8'h03);
    chk("R3 read+write accepted", cpuRdData, 8'h03);
  endtask

  task automatic testOut();
    sieOutDone = 1; tick();
    chk("R9 out flag", cpuRdData, 8'h23);
    cpuRead(); cpuWrite(8'h03);
    chk("R4 out flag cleared", cpuRdData, 8'h03);
  endtask

  task automatic testMode();
    sieModeWr = 1; sieModeData = 4'h9; tick();
    chk("R11 sie mode", cpuRdData, 8'h09);
    cpuWrite(8'h02);
    chk("R2 mode write ignored", cpuRdData, 8'h09);
    cpuRead(); cpuWrite(8'h02);
    chk("R11 cpu mode after unlock", cpuRdData, 8'h02);
  endtask

  task automatic testSetup();
    sieSetupStart = 1; tick();
    chk("R5 setup set", cpuRdData, 8'h82);
    cpuBufWrReq = 1; #1;
    chk("R7 buffer blocked", {7'd0, cpuBufWrEn}, 8'h00);
    sieInAcked = 1; tick();
    cpuRead(); cpuWrite(8'h07);
    chk("R5 setup held in window", cpuRdData, 8'h87);
    sieSetupAck = 1; tick();
    cpuRead();
    chk("R6 setup stays after ack", cpuRdData, 8'h87);
    chk("R7 still blocked", {7'd0, cpuBufWrEn}, 8'h00);
    cpuWrite(8'h01);
    chk("R6 write clears setup", cpuRdData, 8'h01);
    chk("R7 buffer open", {7'd0, cpuBufWrEn}, 8'h01);
    cpuBufWrReq = 0; #1;
    chk("R7 no request no enable", {7'd0, cpuBufWrEn}, 8'h00);
  endtask

  task automatic testCollision();
    cpuWr = 1; cpuWrData = 8'h0C; sieAcked = 1; tick();
    chk("R12 sie wins", cpuRdData, 8'h11);
    cpuWrite(8'h0C);
    chk("R12 locked after collision", cpuRdData, 8'h11);
    cpuRdWr(8'h00);
    chk("R3 unlock after collision", cpuRdData, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testLockedWrite();
    testReadUnlock();
    testOut();
    testMode();
    testSetup();
    testCollision();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule